// File: doc/BRIEF.md
# PWM Coil Current Regulator

This block closes the digital current loop for one winding of a stepper motor. It drives the four gate enables of a full H-bridge: a high-side and a low-side switch on each of two legs. Its inputs are a signed current set-point and a single comparator flag that is high while the sensed winding current is above the set-point. The PWM period is counted from the block clock, so the switching rate does not depend on supply, motor speed or load. A rate select halves the period. An optional mode lengthens each period by a pseudo-random 0 to 3 clocks.

A four-state machine picks the bridge phase. ST_OFF holds every switch open. ST_FWD drives the diagonal picked by the set-point sign. ST_SLOW closes both low-side switches so the coil current recirculates. ST_FAST drives the diagonal against the current that is flowing. The transitions are:
- **T_START**: ST_OFF → ST_FWD on a period tick.
- **T_TRIP**: ST_FWD → ST_SLOW when the comparator trips.
- **T_RESUME**: ST_SLOW → ST_FWD on the next period tick.
- **T_DROP**: ST_FWD or ST_SLOW → ST_FAST when the set-point magnitude drops or its sign flips.
- **T_SETTLED**: ST_FAST → ST_FWD when the comparator clears.
- **T_DISABLE**: any state → ST_OFF when the bridge enable is low.

Forward drive has no fixed cap inside the period, so the duty cycle can go well past one half. A per-leg interlock adds a dead interval before any switch turns on.

Top module: `creg_pwm_regulator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four gate outputs and `period_tick` are low.
- R2: `period_tick` pulses once every 175 clocks with `dbl_rate`=0 and once every 88 clocks with `dbl_rate`=1. A change of `dbl_rate` takes effect from the next period boundary.
- R3: With `jitter_en`=1, each period is 175+k clocks with k in 0..3, and k varies from period to period. With `jitter_en`=0 the period is exact.
- R4: Forward drive starts on a period tick. For a set-point with bit SP_W-1 = 0, forward drive means `gate_hs_a` and `gate_ls_b` are on. For a negative set-point it means `gate_hs_b` and `gate_ls_a` are on.
- R5: When the comparator goes high during forward drive, both low-side gates turn on and both high-side gates turn off. This slow decay holds until the next period tick and then forward drive resumes.
- R6: While the set-point keeps its sign and its magnitude never decreases, the diagonal opposite to forward drive is never driven.
- R7: When the set-point magnitude decreases, or its sign flips, while the bridge is enabled, the block drives the diagonal opposite to the previous set-point's forward diagonal. This fast decay lasts until the comparator is low, and then forward drive follows.
- R8: The high-side and low-side gates of one leg are never on together. Each turn-on of a gate is preceded by at least 4 cycles in which both gates of that leg are off.
- R9: From the second clock edge after `bridge_en` goes low, all four gates are off, and they stay off while it remains low.
- R10: With the comparator held low, the forward diagonal is on for at least 171 of the 175 cycles of a normal-rate period, so the duty cycle goes beyond 50 %.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (oscillator) |
| rst_n | input | 1 | Active-low asynchronous reset |
| bridge_en | input | 1 | 1 enables the bridge, 0 opens all switches |
| dbl_rate | input | 1 | 1 selects the half-length PWM period |
| jitter_en | input | 1 | 1 adds a pseudo-random 0..3 clocks to each period |
| setpoint | input | SP_W | Signed two's-complement current set-point |
| over_cur | input | 1 | Comparator: sensed current above set-point |
| gate_hs_a | output | 1 | High-side switch, leg A |
| gate_ls_a | output | 1 | Low-side switch, leg A |
| gate_hs_b | output | 1 | High-side switch, leg B |
| gate_ls_b | output | 1 | Low-side switch, leg B |
| period_tick | output | 1 | One-cycle pulse on the last count of each PWM period |

## Verification
The embedded properties assume the set-point and comparator flag are synchronous to `clk` and change only between edges. They also assume the comparator reflects real current, so it eventually clears during fast decay. The stimulus keeps to this by driving every input on the falling clock edge. In the steady-state segment the set-point sign stays fixed and its magnitude only grows, which is the condition under which fast decay must never appear. A separate unconstrained segment changes the set-point, comparator, rate and enable at random, and it checks only the interlock and the dead gap.

// File: rtl/creg_pkg.sv
package creg_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_FWD  = 2'd1,
        ST_SLOW = 2'd2,
        ST_FAST = 2'd3
    } creg_state_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } leg_req_t;

    localparam int LEG_A = 0;
    localparam int LEG_B = 1;
    localparam int N_LEGS = 2;

endpackage

// File: rtl/creg_period_gen.sv
module creg_period_gen #(
    parameter int FULL_PERIOD = 175,
    parameter int JIT_W       = 2,
    parameter int LFSR_W      = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'hA5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dbl_i,
    input  logic jit_en_i,
    output logic tick_o
);
    localparam int HALF_PERIOD = (FULL_PERIOD + 1) / 2;
    localparam int MAX_LIMIT   = FULL_PERIOD - 1 + (1 << JIT_W) - 1;
    localparam int CNT_W       = $clog2(MAX_LIMIT + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lim_q;
    logic [CNT_W-1:0]  lim_next;
    logic [CNT_W-1:0]  base_lim;
    logic [CNT_W-1:0]  jit_add;
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_next;

    assign tick_o    = (cnt_q == lim_q);
    assign base_lim  = dbl_i ? CNT_W'(HALF_PERIOD - 1) : CNT_W'(FULL_PERIOD - 1);
    assign jit_add   = jit_en_i ? CNT_W'(lfsr_q[JIT_W-1:0]) : '0;
    assign lim_next  = base_lim + jit_add;
    assign lfsr_next = {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? LFSR_TAPS : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lim_q  <= CNT_W'(FULL_PERIOD - 1);
            lfsr_q <= LFSR_SEED;
        end else if (tick_o) begin
            cnt_q  <= '0;
            lim_q  <= lim_next;
            lfsr_q <= lfsr_next;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q); // R2
    AST_LIMIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        lim_q <= CNT_W'(MAX_LIMIT)); // R3
    AST_LFSR_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R3

endmodule

// File: rtl/creg_decay_fsm.sv
module creg_decay_fsm
    import creg_pkg::*;
#(
    parameter int SP_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bridge_en_i,
    input  logic                tick_i,
    input  logic                over_cur_i,
    input  logic [SP_W-1:0]     setpoint_i,
    output leg_req_t [N_LEGS-1:0] leg_req_o
);
    creg_state_e     state_q;
    creg_state_e     state_d;
    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] mag_now;
    logic [SP_W-1:0] mag_prev;
    logic            sign_now;
    logic            sign_prev;
    logic            sp_drop;
    logic            fast_neg_q;

    assign sign_now  = setpoint_i[SP_W-1];
    assign sign_prev = sp_q[SP_W-1];
    assign mag_now   = sign_now  ? (~setpoint_i + SP_W'(1)) : setpoint_i;
    assign mag_prev  = sign_prev ? (~sp_q + SP_W'(1))       : sp_q;
    assign sp_drop   = (sign_now != sign_prev) || (mag_now < mag_prev);

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (!bridge_en_i) begin
            state_d = ST_OFF;                                  // T_DISABLE
        end else begin
            unique case (state_q)
                ST_OFF:  if (tick_i) state_d = ST_FWD;         // T_START
                ST_FWD: begin
                    if (sp_drop)         state_d = ST_FAST;    // T_DROP
                    else if (over_cur_i) state_d = ST_SLOW;    // T_TRIP
                end
                ST_SLOW: begin
                    if (sp_drop)     state_d = ST_FAST;        // T_DROP
                    else if (tick_i) state_d = ST_FWD;         // T_RESUME
                end
                ST_FAST: if (!over_cur_i) state_d = ST_FWD;    // T_SETTLED
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_OFF;
            sp_q       <= '0;
            fast_neg_q <= 1'b0;
        end else begin
            state_q <= state_d;
            sp_q    <= setpoint_i;
            if (state_d == ST_FAST && state_q != ST_FAST)
                fast_neg_q <= sign_prev;
        end
    end

    // switch requests per state
    always_comb begin
        leg_req_o = '0;
        unique case (state_q)
            ST_OFF: leg_req_o = '0;
            ST_FWD: begin
                if (sign_now) begin
                    leg_req_o[LEG_B].hs = 1'b1;
                    leg_req_o[LEG_A].ls = 1'b1;
                end else begin
                    leg_req_o[LEG_A].hs = 1'b1;
                    leg_req_o[LEG_B].ls = 1'b1;
                end
            end
            ST_SLOW: begin
                leg_req_o[LEG_A].ls = 1'b1;
                leg_req_o[LEG_B].ls = 1'b1;
            end
            ST_FAST: begin
                if (fast_neg_q) begin
                    leg_req_o[LEG_A].hs = 1'b1;
                    leg_req_o[LEG_B].ls = 1'b1;
                end else begin
                    leg_req_o[LEG_B].hs = 1'b1;
                    leg_req_o[LEG_A].ls = 1'b1;
                end
            end
            default: leg_req_o = '0;
        endcase
    end

    AST_FAST_NEEDS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAST && $past(state_q) != ST_FAST) |-> $past(sp_drop)); // R7
    AST_SLOW_EXIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SLOW && state_q == ST_FWD) |-> $past(tick_i)); // R5
    AST_DRIVE_STARTS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_OFF && state_q != ST_OFF) |-> $past(tick_i)); // R4

endmodule

// File: rtl/creg_deadband.sv
module creg_deadband
    import creg_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_req_t req_i,
    output logic     hs_o,
    output logic     ls_o
);
    localparam int IW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
    localparam logic [IW-1:0] IDLE_MAX = IW'(DEAD_CYC - 1);

    logic [IW-1:0] idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_o   <= 1'b0;
            ls_o   <= 1'b0;
            idle_q <= IDLE_MAX;
        end else if (hs_o || ls_o) begin
            idle_q <= '0;
            if (hs_o && !req_i.hs) hs_o <= 1'b0;
            if (ls_o && !req_i.ls) ls_o <= 1'b0;
        end else begin
            if (idle_q < IDLE_MAX) idle_q <= idle_q + IW'(1);
            if (idle_q >= IDLE_MAX) begin
                hs_o <= req_i.hs;
                ls_o <= req_i.ls;
            end
        end
    end

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i.hs && req_i.ls)); // R8

endmodule

// File: rtl/creg_pwm_regulator.sv
module creg_pwm_regulator
    import creg_pkg::*;
#(
    parameter int SP_W        = 9,
    parameter int FULL_PERIOD = 175,
    parameter int DEAD_CYC    = 4,
    parameter int JIT_W       = 2,
    parameter int LFSR_W      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bridge_en,
    input  logic            dbl_rate,
    input  logic            jitter_en,
    input  logic [SP_W-1:0] setpoint,
    input  logic            over_cur,
    output logic            gate_hs_a,
    output logic            gate_ls_a,
    output logic            gate_hs_b,
    output logic            gate_ls_b,
    output logic            period_tick
);
    localparam int GAP_W = $clog2(DEAD_CYC + 1);

    leg_req_t [N_LEGS-1:0] leg_req;
    logic     [N_LEGS-1:0] hs_w;
    logic     [N_LEGS-1:0] ls_w;

    creg_period_gen #(
        .FULL_PERIOD(FULL_PERIOD),
        .JIT_W      (JIT_W),
        .LFSR_W     (LFSR_W)
    ) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .dbl_i   (dbl_rate),
        .jit_en_i(jitter_en),
        .tick_o  (period_tick)
    );

    creg_decay_fsm #(.SP_W(SP_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bridge_en_i(bridge_en),
        .tick_i     (period_tick),
        .over_cur_i (over_cur),
        .setpoint_i (setpoint),
        .leg_req_o  (leg_req)
    );

    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        creg_deadband #(.DEAD_CYC(DEAD_CYC)) u_db (
            .clk  (clk),
            .rst_n(rst_n),
            .req_i(leg_req[g]),
            .hs_o (hs_w[g]),
            .ls_o (ls_w[g])
        );

        // run length of both-off cycles seen at this leg's outputs
        logic [GAP_W-1:0] off_run_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      off_run_q <= GAP_W'(DEAD_CYC);
            else if (hs_w[g] || ls_w[g])     off_run_q <= '0;
            else if (off_run_q < GAP_W'(DEAD_CYC)) off_run_q <= off_run_q + GAP_W'(1);
        end

        AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
            !(hs_w[g] && ls_w[g])); // R8
        AST_DEAD_GAP_HS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hs_w[g]) |-> off_run_q >= GAP_W'(DEAD_CYC)); // R8
        AST_DEAD_GAP_LS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ls_w[g]) |-> off_run_q >= GAP_W'(DEAD_CYC)); // R8
    end

    assign gate_hs_a = hs_w[LEG_A];
    assign gate_ls_a = ls_w[LEG_A];
    assign gate_hs_b = hs_w[LEG_B];
    assign gate_ls_b = ls_w[LEG_B];

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!bridge_en && $past(!bridge_en) && $past(!bridge_en, 2))
            |-> (hs_w == '0 && ls_w == '0)); // R9

endmodule

// File: tb/creg_pwm_regulator_tb.sv
module creg_pwm_regulator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SP_W       = 9;
    localparam int FULL       = 175;
    localparam int HALF       = 88;
    localparam int DEAD       = 4;
    localparam logic [3:0] PAT_OFF  = 4'b0000;
    localparam logic [3:0] PAT_POS  = 4'b1001; // {hs_a, ls_a, hs_b, ls_b}
    localparam logic [3:0] PAT_NEG  = 4'b0110;
    localparam logic [3:0] PAT_SLOW = 4'b0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bridge_en, dbl_rate, jitter_en, over_cur;
    logic [SP_W-1:0] setpoint;
    logic gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b, period_tick;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit steady_pos = 1'b0;
    bit dis_watch = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    creg_pwm_regulator u_dut (
        .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .dbl_rate(dbl_rate),
        .jitter_en(jitter_en), .setpoint(setpoint), .over_cur(over_cur),
        .gate_hs_a(gate_hs_a), .gate_ls_a(gate_ls_a), .gate_hs_b(gate_hs_b),
        .gate_ls_b(gate_ls_b), .period_tick(period_tick)
    );

    wire [3:0] gates = {gate_hs_a, gate_ls_a, gate_hs_b, gate_ls_b};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] fwd_pat(input logic [SP_W-1:0] sp);
        return sp[SP_W-1] ? PAT_NEG : PAT_POS;
    endfunction

    function automatic logic [3:0] fast_pat(input logic [SP_W-1:0] old_sp);
        return old_sp[SP_W-1] ? PAT_POS : PAT_NEG;
    endfunction

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!period_tick);
    endtask

    task automatic measure(output int len);
        len = 0;
        do begin @(negedge clk); len++; end while (!period_tick);
    endtask

    // interlock, dead gap, steady-state and disable monitor
    int off_run [2] = '{100, 100};
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int l = 0; l < 2; l++) begin
                logic hs, ls;
                hs = (l == 0) ? gate_hs_a : gate_hs_b;
                ls = (l == 0) ? gate_ls_a : gate_ls_b;
                chk(!(hs && ls), "R8 shoot-through", int'({hs, ls}), 1);
                if (hs || ls) begin
                    if (off_run[l] != 0)
                        chk(off_run[l] >= DEAD, "R8 dead gap", off_run[l], DEAD);
                    off_run[l] = 0;
                end else begin
                    off_run[l]++;
                end
            end
            if (steady_pos)
                chk(gates != PAT_NEG, "R6 no fast decay in steady state", int'(gates), int'(PAT_POS));
            if (dis_watch)
                chk(gates == PAT_OFF, "R9 off while disabled", int'(gates), 0);
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int len;
        int lo, hi;
        logic [SP_W-1:0] old_sp;
        void'($urandom(32'h5EED_0042));
        bridge_en = 1'b1; dbl_rate = 1'b0; jitter_en = 1'b0; over_cur = 1'b0;
        setpoint = 9'sd100;

        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(gates == PAT_OFF && !period_tick, "R1 during reset", int'({gates, period_tick}), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(gates == PAT_OFF && !period_tick, "R1 after reset", int'({gates, period_tick}), 0);

        // R2 normal period; R4 forward starts on tick
        wait_tick();
        measure(len);
        chk(len == FULL, "R2 normal period", len, FULL);
        cyc(8);
        chk(gates == PAT_POS, "R4 positive forward", int'(gates), int'(PAT_POS));

        // R10 duty over a full period with comparator low
        wait_tick();
        len = 0;
        for (int i = 0; i < FULL; i++) begin
            @(negedge clk);
            if (gates == PAT_POS) len++;
        end
        chk(len >= FULL - DEAD, "R10 forward duty", len, FULL - DEAD);

        // R5 slow decay until next tick
        wait_tick();
        cyc(20);
        over_cur = 1'b1;
        cyc(8);
        chk(gates == PAT_SLOW, "R5 slow decay entered", int'(gates), int'(PAT_SLOW));
        over_cur = 1'b0;
        cyc(20);
        chk(gates == PAT_SLOW, "R5 slow decay held", int'(gates), int'(PAT_SLOW));
        wait_tick();
        cyc(8);
        chk(gates == PAT_POS, "R5 forward resumes after tick", int'(gates), int'(PAT_POS));

        // R4 negative diagonal
        setpoint = -9'sd100;
        cyc(8);
        chk(gates == PAT_NEG, "R4 negative forward", int'(gates), int'(PAT_NEG));

        // R7 fast decay, negative set-point magnitude drop
        old_sp = setpoint;
        setpoint = -9'sd30; over_cur = 1'b1;
        cyc(8);
        chk(gates == fast_pat(old_sp), "R7 fast decay negative", int'(gates), int'(fast_pat(old_sp)));
        cyc(30);
        chk(gates == fast_pat(old_sp), "R7 fast decay holds", int'(gates), int'(fast_pat(old_sp)));
        over_cur = 1'b0;
        cyc(8);
        chk(gates == fwd_pat(setpoint), "R7 forward after fast", int'(gates), int'(fwd_pat(setpoint)));

        // R7 sign flip then positive drop
        setpoint = 9'sd90;
        cyc(8);
        chk(gates == PAT_POS, "R7 sign flip settles forward", int'(gates), int'(PAT_POS));
        old_sp = setpoint;
        setpoint = 9'sd20; over_cur = 1'b1;
        cyc(8);
        chk(gates == fast_pat(old_sp), "R7 fast decay positive", int'(gates), int'(fast_pat(old_sp)));
        over_cur = 1'b0;
        cyc(8);
        chk(gates == PAT_POS, "R7 forward after positive fast", int'(gates), int'(PAT_POS));

        // R9 bridge disable with random other inputs
        bridge_en = 1'b0;
        cyc(3);
        dis_watch = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            setpoint = SP_W'($urandom);
            over_cur = 1'($urandom);
        end
        dis_watch = 1'b0;
        setpoint = 9'sd20; over_cur = 1'b0;
        bridge_en = 1'b1;
        wait_tick();
        cyc(8);
        chk(gates == PAT_POS, "R9 drive returns after enable", int'(gates), int'(PAT_POS));

        // R2 double rate
        dbl_rate = 1'b1;
        wait_tick();
        measure(len);
        chk(len == HALF, "R2 double period", len, HALF);
        measure(len);
        chk(len == HALF, "R2 double period repeat", len, HALF);
        dbl_rate = 1'b0;
        wait_tick();
        measure(len);
        chk(len == FULL, "R2 back to normal period", len, FULL);

        // R3 jitter
        jitter_en = 1'b1;
        wait_tick();
        lo = 1000; hi = 0;
        for (int p = 0; p < 30; p++) begin
            measure(len);
            chk(len >= FULL && len <= FULL + 3, "R3 jittered period range", len, FULL);
            if (len < lo) lo = len;
            if (len > hi) hi = len;
        end
        chk(hi > lo, "R3 jitter varies", hi - lo, 1);
        jitter_en = 1'b0;
        wait_tick();
        measure(len);
        chk(len == FULL, "R3 jitter off exact", len, FULL);

        // R6 steady state: sign fixed, magnitude never drops
        cyc(10);
        steady_pos = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom % 8 == 0) over_cur = ~over_cur;
            if (i % 64 == 0 && setpoint < 9'sd240) setpoint = setpoint + SP_W'($urandom % 8);
        end
        steady_pos = 1'b0;

        // R8 unconstrained random: interlock and dead gap by monitor
        over_cur = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if ($urandom % 40 == 0) setpoint = SP_W'($urandom);
            if ($urandom % 6 == 0)  over_cur = 1'($urandom);
            if ($urandom % 500 == 0) dbl_rate = 1'($urandom);
            if ($urandom % 300 == 0) jitter_en = 1'($urandom);
            if ($urandom % 200 == 0) bridge_en = ($urandom % 4) != 0;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule